// File: doc/BRIEF.md
# Registered Load Data Aligner

This block sits directly after a 64-bit single-port data memory. It takes the full-width word that the memory array presents and captures it, untouched, in a wide register. Only after that register does it select the addressed 8-, 16-, 32- or 64-bit field and move it to the bottom of the load result bus. The access size code and the low address bits are delayed in their own registers on the same edge, so the lane select never sits between the array and its first register. This ordering leaves the array free to map onto a dedicated synchronous memory macro.

A read is taken only when the clock enable, the read enable and the address-range check all agree on a rising edge. The range check accepts an address only if every bit above the data-memory address width is zero. Anything higher belongs to code space and produces no load. The result appears with a one-cycle valid flag after the capturing edge. While the clock enable is low, the whole pipeline freezes.

Top module: `load_lane_aligner`

## Requirements
- R1: Size code 0 is a byte load. Address bits [2:0] pick the lane, where lane k is bits [8k+7:8k] of the memory word (lane 0 is bits [7:0], lane 7 is bits [63:56]).
- R2: Size code 1 is a 16-bit load. Address bits [2:1] pick one of four halfwords, where halfword k is bits [16k+15:16k].
- R3: Size code 2 is a 32-bit load. Address bit [2] picks the low word [31:0] (0) or the high word [63:32] (1).
- R4: Size code 3 returns the whole 64-bit memory word unchanged, whatever the low address bits are.
- R5: Address bits below the selected lane have no effect on the result.
- R6: After a rising edge on which clk_en, rd_en and the range check are all high, load_valid is 1 and load_data holds the selected field, until the next enabled edge. Back-to-back reads give one result per cycle.
- R7: An enabled edge with rd_en low clears load_valid and leaves load_data unchanged.
- R8: A read whose address has any bit at or above MEM_AW set produces no load: load_valid is 0 after it and load_data is unchanged. Address 2**MEM_AW-1 is still accepted.
- R9: While clk_en is low, load_valid and load_data hold their values, even if rd_en is high.
- R10: Narrow results are zero-extended: every bit of load_data above the field width is 0.
- R11: A synchronous reset clears load_valid. It also clears the delayed size and offset.
- R12: The size code and offset are taken at the capturing edge. Later changes to size, addr or ram_rdata without a new qualified read leave load_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Pipeline advance enable |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W (32) | Byte address of the access |
| size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| ram_rdata | input | DATA_W (64) | Raw read word from the memory array |
| load_data | output | DATA_W (64) | Right-justified, zero-extended load result |
| load_valid | output | 1 | High for the cycle after a qualified read |

## Verification
The hardest case to reach is a valid result held across stalled cycles. A read is captured, and clk_en then drops while rd_en, addr, size and ram_rdata keep changing. The flag must stay high and the data must not move. The stimulus builds this by following a qualified read with stalled cycles that present new sizes, offsets and words, and also an out-of-range address. It then releases the stall with rd_en low and checks that the flag clears while the old field stays on the bus. A behavioural model updated at every edge is compared with both outputs on every falling edge.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam int NUM_SIZES = 4;

endpackage

// File: rtl/aligner_range_chk.sv
module aligner_range_chk #(
    parameter int ADDR_W = 32,
    parameter int MEM_AW = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    generate
        if (MEM_AW >= ADDR_W) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = (addr[ADDR_W-1:MEM_AW] == '0);
        end
    endgenerate
endmodule

// File: rtl/aligner_capture.sv
module aligner_capture #(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              rd_en,
    input  logic              in_range,
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              valid_q,
    output logic [1:0]        size_q,
    output logic [OFF_W-1:0]  off_q,
    output logic [DATA_W-1:0] data_q
);
    typedef struct packed {
        logic              valid;
        logic [1:0]        size;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       take;

    assign take = clk_en & rd_en & in_range;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            st_d.valid = rd_en & in_range;
            if (take) begin
                st_d.size = size;
                st_d.off  = off;
                st_d.data = ram_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.valid <= 1'b0;
            st_q.size  <= '0;
            st_q.off   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_q = st_q.valid;
    assign size_q  = st_q.size;
    assign off_q   = st_q.off;
    assign data_q  = st_q.data;

    // R12
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(clk_en && rd_en && in_range) |=> ($stable(data_q) && $stable(size_q) && $stable(off_q)));

endmodule

// File: rtl/aligner_lane_mux.sv
module aligner_lane_mux
    import aligner_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        size_q,
    input  logic [OFF_W-1:0]  off_q,
    input  logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] field
);
    logic [DATA_W-1:0] cand [NUM_SIZES];

    generate
        for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
            localparam int FW = 8 << s;
            localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - FW);
            logic [OFF_W-1:0]  idx;
            logic [DATA_W-1:0] shifted;
            assign idx     = off_q >> s;
            assign shifted = data_q >> (idx * FW);
            assign cand[s] = shifted & MASK;
        end
    endgenerate

    always_comb begin
        unique case (acc_size_e'(size_q))
            SZ_BYTE:  field = cand[0];
            SZ_HALF:  field = cand[1];
            SZ_WORD:  field = cand[2];
            default:  field = cand[3];
        endcase
    end

    // R10
    zero_ext_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (size_q == 2'd0) |-> (field[DATA_W-1:8] == '0));

    // R10
    zero_ext_half_chk: assert property (@(posedge clk) disable iff (rst)
        (size_q == 2'd1) |-> (field[DATA_W-1:16] == '0));

endmodule

// File: rtl/load_lane_aligner.sv
module load_lane_aligner #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] load_data,
    output logic              load_valid
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic              in_range;
    logic [1:0]        size_q;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] data_q;

    aligner_range_chk #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_range (
        .addr     (addr),
        .in_range (in_range)
    );

    aligner_capture #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .rd_en     (rd_en),
        .in_range  (in_range),
        .size      (size),
        .off       (addr[OFF_W-1:0]),
        .ram_rdata (ram_rdata),
        .valid_q   (load_valid),
        .size_q    (size_q),
        .off_q     (off_q),
        .data_q    (data_q)
    );

    aligner_lane_mux #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_mux (
        .clk    (clk),
        .rst    (rst),
        .size_q (size_q),
        .off_q  (off_q),
        .data_q (data_q),
        .field  (load_data)
    );

    // R6
    qualified_read_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && rd_en && in_range) |=> load_valid);

    // R8
    code_space_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !in_range) |=> !load_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(load_valid) && $stable(load_data)));

endmodule

// File: tb/load_lane_aligner_tb.sv
module load_lane_aligner_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        clk_en;
    logic        rd_en;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [63:0] ram_rdata;
    logic [63:0] load_data;
    logic        load_valid;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R11";

    // behavioural reference state
    bit          m_valid = 1'b0;
    bit          m_known = 1'b0;
    logic [63:0] m_word = '0;
    int          m_sz = 0;
    int          m_off = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_lane_aligner u_dut (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .size       (size),
        .ram_rdata  (ram_rdata),
        .load_data  (load_data),
        .load_valid (load_valid)
    );

    function automatic logic [63:0] expect_field(logic [63:0] w, int sz, int off);
        logic [63:0] r;
        int nb;
        int base;
        r = '0;
        nb = 1 << sz;
        base = off - (off % nb);
        for (int b = 0; b < nb; b++) begin
            r[b*8 +: 8] = w[(base + b)*8 +: 8];
        end
        return r;
    endfunction

    task automatic compare();
        logic [63:0] exp_d;
        checks++;
        if (load_valid !== m_valid) begin
            failures++;
            $display("FAIL %s: load_valid actual=%0b expected=%0b", cur_tag, load_valid, m_valid);
        end
        if (m_known) begin
            exp_d = expect_field(m_word, m_sz, m_off);
            checks++;
            if (load_data !== exp_d) begin
                failures++;
                $display("FAIL %s: load_data actual=%h expected=%h", cur_tag, load_data, exp_d);
            end
        end
    endtask

    task automatic step(input bit r, input bit cen, input bit ren, input logic [31:0] a,
                        input int sz, input logic [63:0] w, input string tag);
        rst = r; clk_en = cen; rd_en = ren; addr = a; size = sz[1:0]; ram_rdata = w;
        cur_tag = tag;
        @(posedge clk);
        if (r) begin
            m_valid = 1'b0; m_sz = 0; m_off = 0;
        end else if (cen) begin
            m_valid = ren && (a[31:16] == 16'd0);
            if (m_valid) begin
                m_word = w; m_sz = sz; m_off = int'(a[2:0]); m_known = 1'b1;
            end
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] pat;
        pat = 64'h8877_6655_4433_2211;
        // R11: reset state
        for (int i = 0; i < 3; i++) step(1, 1, 1, 32'h10, 3, pat, "R11");
        // R4: full word, any offset
        step(0, 1, 1, 32'h0000_0100, 3, pat, "R4");
        step(0, 1, 1, 32'h0000_0105, 3, 64'hDEAD_BEEF_0123_4567, "R4");
        // R1 + R10: every byte lane
        for (int k = 0; k < 8; k++) step(0, 1, 1, 32'h200 + k, 0, pat ^ 64'hF0F0_F0F0_F0F0_F0F0, "R1");
        step(0, 1, 1, 32'h307, 0, 64'hFF00_0000_0000_0000, "R10");
        // R2 + R5: halfword lanes with odd low bit
        for (int k = 0; k < 8; k++) step(0, 1, 1, 32'h400 + k, 1, pat, (k % 2) ? "R5" : "R2");
        // R3 + R5: word lanes
        for (int k = 0; k < 8; k++) step(0, 1, 1, 32'h500 + k, 2, 64'hCAFE_F00D_1357_9BDF, (k % 4) ? "R5" : "R3");
        step(0, 1, 1, 32'h504, 2, 64'hFFFF_FFFF_0000_0000, "R10");
        // R6: back-to-back then idle
        step(0, 1, 1, 32'h602, 1, 64'h0102_0304_0506_0708, "R6");
        step(0, 1, 1, 32'h603, 0, 64'hA1B2_C3D4_E5F6_0718, "R6");
        // R7: enabled edge without read
        step(0, 1, 0, 32'h700, 3, 64'h5555_5555_5555_5555, "R7");
        step(0, 1, 0, 32'h701, 2, 64'h6666_6666_6666_6666, "R7");
        // R8: code space rejected, top of range accepted
        step(0, 1, 1, 32'h0000_FFFF, 0, pat, "R8");
        step(0, 1, 1, 32'h0001_0000, 3, 64'h1111_2222_3333_4444, "R8");
        step(0, 1, 1, 32'h8000_0003, 0, 64'h9999_9999_9999_9999, "R8");
        step(0, 1, 1, 32'h0000_FFFE, 1, 64'hABCD_0000_0000_0000, "R8");
        // R9: stalls hold a valid result
        step(0, 1, 1, 32'h0000_0804, 2, 64'h7654_3210_FEDC_BA98, "R9");
        step(0, 0, 1, 32'h0000_0800, 3, 64'h0, "R9");
        step(0, 0, 1, 32'h0000_0801, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        step(0, 0, 1, 32'h0002_0000, 1, 64'h1234, "R9");
        step(0, 0, 0, 32'h0000_0806, 1, 64'h1234, "R9");
        // R12: live inputs change, no new read
        step(0, 1, 0, 32'h0000_0807, 0, 64'hEEEE_EEEE_EEEE_EEEE, "R12");
        step(0, 1, 0, 32'h0000_0800, 3, 64'hDDDD_DDDD_DDDD_DDDD, "R12");
        // R11: reset mid-run clears valid
        step(0, 1, 1, 32'h0000_0900, 3, pat, "R11");
        step(1, 1, 1, 32'h0000_0900, 3, pat, "R11");
        step(0, 0, 0, 32'h0, 0, 64'h0, "R11");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule